// File: doc/BRIEF.md
# Interleaved DRAM Range Router

This block decides which memory node owns a physical address. It holds a small table of address windows. Each window has a lower word and an upper word. Each word carries a 16-bit page number, which is address bits 39:24, so windows are placed at 16 MB granularity. The lower word also holds the read and write permissions and an interleave code. The upper word also holds the destination node and an interleave select value.

A request gives a 40-bit address and a write flag. One cycle later the block reports whether a window claimed the request, which node owns it, and which window matched. When interleaving is on, several windows can cover the same pages. Each window then claims only the addresses whose bits A[14:12] equal its select value, in the bit positions that the code enables. This spreads consecutive 4 KB blocks over 2, 4 or 8 nodes.

Software programs the table through a simple write port and reads it back through a combinational read port. It writes the upper word of a window before the lower word, because the permissions that arm the window sit in the lower word.

Top module: `dram_route_top`

## Requirements
- R1: After reset every stored word reads as zero and every request misses.
- R2: A write keeps only the defined bits and stores zero in all others. Lower word keep mask: 0xFFFF0703 (page at bits 31:16, interleave code at 10:8, write permission at bit 1, read permission at bit 0). Upper word keep mask: 0xFFFF0707 (page at 31:16, select at 10:8, node at 2:0). The selector `cfg_wr_limit`=1 addresses the upper word.
- R3: A window's range covers a request when address bits 39:24 are at least the lower page and at most the upper page. Both bounds are inclusive.
- R4: A read request (`req_write`=0) needs bit 0 of the lower word set. A write request needs bit 1 set. A request whose permission bit is clear never hits that window.
- R5: Interleave codes are in lower-word bits 10:8. Code 000 applies no interleave test. Code 001 requires A[12] to equal select bit 0. Code 011 requires A[12] and A[14] to equal select bits 0 and 2, and A[13] is ignored. Code 111 requires A[14:12] to equal the whole select value.
- R6: A window whose interleave code is 010, 100, 101 or 110 never hits.
- R7: When several windows hit, the response reports the lowest window index.
- R8: A valid request that hits no window gives `rsp_hit`=0, `rsp_node`=0 and `rsp_idx`=0.
- R9: `rsp_valid` is `req_valid` delayed by one cycle. The response reflects the table as it stood in the request's cycle. On a hit, `rsp_node` is bits 2:0 of the winning window's upper word.
- R10: In a cycle after `req_valid` was low, `rsp_valid` and `rsp_hit` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_wr_limit | input | 1 | 1 selects the upper word, 0 selects the lower word |
| cfg_wr_idx | input | 3 | Window index to write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_idx | input | 3 | Window index to read |
| cfg_rd_limit | input | 1 | 1 reads the upper word, 0 reads the lower word |
| cfg_rd_data | output | 32 | Read data (combinational) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 40 | Physical address |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_node | output | 3 | Destination node |
| rsp_idx | output | 3 | Index of the winning window |

## Verification
The assertions compare each response against a snapshot of the table taken in the request's cycle. They therefore assume that no table write lands in the same cycle as a request the bench means to predict. The bench keeps table writes and requests in separate cycles and programs a window's upper word before its lower word. Random windows use small page values and short spans so that overlaps, boundary pages and misses all occur often. Random interleave codes include the reserved ones.

// File: rtl/dram_route_pkg.sv
package dram_route_pkg;
   localparam int WORD_W     = 32;
   localparam int PAGE_MSB   = 31;
   localparam int PAGE_LSB   = 16;
   localparam int FIELD_LSB  = 8;
   localparam int NODE_W     = 3;
   localparam int ILV_W      = 3;
   localparam int ILV_ALSB   = 12;
   localparam logic [WORD_W-1:0] LOWER_KEEP = 32'hFFFF_0703;
   localparam logic [WORD_W-1:0] UPPER_KEEP = 32'hFFFF_0707;

   typedef struct packed {
      logic             legal;
      logic [ILV_W-1:0] mask;
   } ilv_dec_t;

   function automatic ilv_dec_t ilv_decode(input logic [ILV_W-1:0] code);
      ilv_dec_t d;
      case (code)
         3'b000:  d = '{legal: 1'b1, mask: 3'b000};
         3'b001:  d = '{legal: 1'b1, mask: 3'b001};
         3'b011:  d = '{legal: 1'b1, mask: 3'b101};
         3'b111:  d = '{legal: 1'b1, mask: 3'b111};
         default: d = '{legal: 1'b0, mask: 3'b000};
      endcase
      return d;
   endfunction
endpackage

// File: rtl/dram_route_regs.sv
module dram_route_regs
   import dram_route_pkg::*;
#(
   parameter int NUM_RANGES = 8,
   parameter int IDX_W      = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic                              wr_limit,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [WORD_W-1:0]                 wr_data,
   input  logic [IDX_W-1:0]                  rd_idx,
   input  logic                              rd_limit,
   output logic [NUM_RANGES-1:0][WORD_W-1:0] lower_q,
   output logic [NUM_RANGES-1:0][WORD_W-1:0] upper_q,
   output logic [WORD_W-1:0]                 rd_data
);
   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lower_q[i] <= '0;
            upper_q[i] <= '0;
         end else if (sel) begin
            if (wr_limit) upper_q[i] <= wr_data & UPPER_KEEP;
            else          lower_q[i] <= wr_data & LOWER_KEEP;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_RANGES; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = rd_limit ? upper_q[i] : lower_q[i];
      end
   end
endmodule

// File: rtl/dram_route_match.sv
module dram_route_match
   import dram_route_pkg::*;
#(
   parameter int PAGE_W = 16
) (
   input  logic [WORD_W-1:0] lower_w,
   input  logic [WORD_W-1:0] upper_w,
   input  logic [PAGE_W-1:0] page,
   input  logic [ILV_W-1:0]  ilv_bits,
   input  logic              is_write,
   output logic              hit
);
   ilv_dec_t   dec;
   logic       in_range;
   logic       kind_ok;
   logic       ilv_ok;

   always_comb begin
      dec      = ilv_decode(lower_w[FIELD_LSB +: ILV_W]);
      in_range = (page >= lower_w[PAGE_MSB -: PAGE_W]) && (page <= upper_w[PAGE_MSB -: PAGE_W]);
      kind_ok  = is_write ? lower_w[1] : lower_w[0];
      ilv_ok   = dec.legal && (((ilv_bits ^ upper_w[FIELD_LSB +: ILV_W]) & dec.mask) == '0);
      hit      = in_range && kind_ok && ilv_ok;
   end
endmodule

// File: rtl/dram_route_arb.sv
module dram_route_arb #(
   parameter int NUM_RANGES = 8,
   parameter int IDX_W      = 3
) (
   input  logic [NUM_RANGES-1:0] hits,
   output logic                  found,
   output logic [IDX_W-1:0]      idx
);
   always_comb begin
      found = |hits;
      idx   = '0;
      for (int i = NUM_RANGES - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/dram_route_top.sv
module dram_route_top
   import dram_route_pkg::*;
#(
   parameter int NUM_RANGES = 8,
   parameter int ADDR_W     = 40,
   parameter int GRAN_LSB   = 24
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_wr_en,
   input  logic                          cfg_wr_limit,
   input  logic [$clog2(NUM_RANGES)-1:0] cfg_wr_idx,
   input  logic [31:0]                   cfg_wr_data,
   input  logic [$clog2(NUM_RANGES)-1:0] cfg_rd_idx,
   input  logic                          cfg_rd_limit,
   output logic [31:0]                   cfg_rd_data,
   input  logic                          req_valid,
   input  logic                          req_write,
   input  logic [ADDR_W-1:0]             req_addr,
   output logic                          rsp_valid,
   output logic                          rsp_hit,
   output logic [2:0]                    rsp_node,
   output logic [$clog2(NUM_RANGES)-1:0] rsp_idx
);
   localparam int IDX_W  = $clog2(NUM_RANGES);
   localparam int PAGE_W = ADDR_W - GRAN_LSB;

   if (NUM_RANGES < 2) begin : g_bad_n
      $error("NUM_RANGES must be at least 2");
   end
   if (PAGE_W != PAGE_MSB - PAGE_LSB + 1) begin : g_bad_page
      $error("ADDR_W - GRAN_LSB must equal the 16-bit page field");
   end
   if (GRAN_LSB <= ILV_ALSB + ILV_W - 1) begin : g_bad_gran
      $error("granule must lie above the interleave bits");
   end

   logic [NUM_RANGES-1:0][WORD_W-1:0] lower_q;
   logic [NUM_RANGES-1:0][WORD_W-1:0] upper_q;
   logic [NUM_RANGES-1:0]             hits;
   logic                              found;
   logic [IDX_W-1:0]                  win_idx;
   logic [PAGE_W-1:0]                 page;
   logic [ILV_W-1:0]                  ilv_bits;

   assign page     = req_addr[ADDR_W-1 -: PAGE_W];
   assign ilv_bits = req_addr[ILV_ALSB +: ILV_W];

   dram_route_regs #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_limit(cfg_wr_limit),
      .wr_idx  (cfg_wr_idx),
      .wr_data (cfg_wr_data),
      .rd_idx  (cfg_rd_idx),
      .rd_limit(cfg_rd_limit),
      .lower_q (lower_q),
      .upper_q (upper_q),
      .rd_data (cfg_rd_data)
   );

   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_win
      dram_route_match #(.PAGE_W(PAGE_W)) u_match (
         .lower_w (lower_q[i]),
         .upper_w (upper_q[i]),
         .page    (page),
         .ilv_bits(ilv_bits),
         .is_write(req_write),
         .hit     (hits[i])
      );
   end

   dram_route_arb #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_arb (
      .hits (hits),
      .found(found),
      .idx  (win_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_node  <= '0;
         rsp_idx   <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid && found) begin
            rsp_hit  <= 1'b1;
            rsp_node <= upper_q[win_idx][NODE_W-1:0];
            rsp_idx  <= win_idx;
         end else begin
            rsp_hit  <= 1'b0;
            rsp_node <= '0;
            rsp_idx  <= '0;
         end
      end
   end
endmodule

// File: rtl/dram_route_chk.sv
module dram_route_chk
   import dram_route_pkg::*;
#(
   parameter int NUM_RANGES = 8,
   parameter int IDX_W      = 3
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              req_valid,
   input logic                              req_write,
   input logic                              rsp_valid,
   input logic                              rsp_hit,
   input logic [2:0]                        rsp_node,
   input logic [IDX_W-1:0]                  rsp_idx,
   input logic [NUM_RANGES-1:0][WORD_W-1:0] lower_q,
   input logic [NUM_RANGES-1:0][WORD_W-1:0] upper_q
);
   logic [NUM_RANGES-1:0][WORD_W-1:0] snap_lower;
   logic [NUM_RANGES-1:0][WORD_W-1:0] snap_upper;
   logic                              snap_wr;
   logic [2:0]                        win_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_lower <= '0;
         snap_upper <= '0;
         snap_wr    <= 1'b0;
      end else begin
         snap_lower <= lower_q;
         snap_upper <= upper_q;
         snap_wr    <= req_write;
      end
   end

   assign win_code = snap_lower[rsp_idx][10:8];

   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_hit));
   // R8
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_node == 3'd0 && rsp_idx == '0));
   // R4
   kind_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (snap_wr ? snap_lower[rsp_idx][1] : snap_lower[rsp_idx][0]));
   // R9
   node_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_node == snap_upper[rsp_idx][2:0]));
   // R6
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (win_code == 3'b000 || win_code == 3'b001 ||
                   win_code == 3'b011 || win_code == 3'b111));

   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_keep
      // R2
      spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((lower_q[i] & ~LOWER_KEEP) == '0) && ((upper_q[i] & ~UPPER_KEEP) == '0));
   end
endmodule

bind dram_route_top dram_route_chk #(.NUM_RANGES(NUM_RANGES), .IDX_W($clog2(NUM_RANGES))) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .rsp_valid(rsp_valid),
   .rsp_hit  (rsp_hit),
   .rsp_node (rsp_node),
   .rsp_idx  (rsp_idx),
   .lower_q  (lower_q),
   .upper_q  (upper_q)
);

// File: tb/dram_route_top_tb.sv
module dram_route_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic        cfg_wr_limit = 1'b0;
   logic [2:0]  cfg_wr_idx = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [2:0]  cfg_rd_idx = '0;
   logic        cfg_rd_limit = 1'b0;
   logic [31:0] cfg_rd_data;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [39:0] req_addr = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [2:0]  rsp_node;
   logic [2:0]  rsp_idx;

   int total = 0;
   int bad = 0;
   logic [31:0] m_lo [8];
   logic [31:0] m_up [8];

   always #4 clk = ~clk;

   dram_route_top u_dut (.*);

   initial begin
      #1600000;
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic [6:0] expect_rsp(input logic [39:0] a, input logic w);
      for (int i = 0; i < 8; i++) begin
         logic [2:0] c, m;
         logic ok;
         c = m_lo[i][10:8];
         ok = 1'b1;
         case (c)
            3'b000: m = 3'b000;
            3'b001: m = 3'b001;
            3'b011: m = 3'b101;
            3'b111: m = 3'b111;
            default: begin m = 3'b000; ok = 1'b0; end
         endcase
         if (a[39:24] < m_lo[i][31:16] || a[39:24] > m_up[i][31:16]) ok = 1'b0;
         if (!(w ? m_lo[i][1] : m_lo[i][0])) ok = 1'b0;
         if (((a[14:12] ^ m_up[i][10:8]) & m) != 3'b000) ok = 1'b0;
         if (ok) return {1'b1, m_up[i][2:0], 3'(i)};
      end
      return 7'd0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int idx, input logic up, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_idx = 3'(idx); cfg_wr_limit = up; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (up) m_up[idx] = d & 32'hFFFF_0707;
      else    m_lo[idx] = d & 32'hFFFF_0703;
   endtask

   task automatic set_win(input int idx, input logic [15:0] lo, input logic [15:0] hi,
                          input logic [2:0] code, input logic [2:0] sel, input logic [2:0] node,
                          input logic [1:0] en);
      wr(idx, 1'b1, {hi, 5'd0, sel, 5'd0, node});
      wr(idx, 1'b0, {lo, 5'd0, code, 6'd0, en});
   endtask

   task automatic clear_all();
      for (int i = 0; i < 8; i++) begin
         wr(i, 1'b0, 32'd0);
         wr(i, 1'b1, 32'd0);
      end
   endtask

   task automatic req(input string tag, input logic [39:0] a, input logic w);
      logic [6:0] e;
      e = expect_rsp(a, w);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, {25'd0, rsp_valid, rsp_hit, rsp_node, rsp_idx}, {25'd0, 1'b1, e});
   endtask

   function automatic logic [39:0] mk(input logic [15:0] pg, input logic [2:0] il);
      return {pg, 8'h00, 1'b0, il, 12'h5A5};
   endfunction

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 8; i++) begin m_lo[i] = '0; m_up[i] = '0; end
      repeat (3) @(negedge clk);
      check("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
         cfg_rd_idx = 3'(i); cfg_rd_limit = 1'b0; #1;
         check("R1 lower reads zero", cfg_rd_data, 32'd0);
         cfg_rd_limit = 1'b1; #1;
         check("R1 upper reads zero", cfg_rd_data, 32'd0);
      end
      req("R1 R8 miss after reset", mk(16'h0000, 3'd0), 1'b0);

      // R2 spare bits
      wr(3, 1'b0, 32'hFFFF_FFFF);
      wr(3, 1'b1, 32'hFFFF_FFFF);
      cfg_rd_idx = 3'd3; cfg_rd_limit = 1'b0; #1;
      check("R2 lower keep", cfg_rd_data, 32'hFFFF_0703);
      cfg_rd_limit = 1'b1; #1;
      check("R2 upper keep", cfg_rd_data, 32'hFFFF_0707);
      clear_all();

      // R3 inclusive bounds
      set_win(0, 16'h0010, 16'h0012, 3'b000, 3'd0, 3'd4, 2'b11);
      req("R3 below base", mk(16'h000F, 3'd7), 1'b0);
      req("R3 at base", mk(16'h0010, 3'd0), 1'b0);
      req("R3 at limit", {16'h0012, 24'hFF_FFFF}, 1'b1);
      req("R3 above limit", mk(16'h0013, 3'd0), 1'b1);

      // R4 permissions
      set_win(0, 16'h0010, 16'h0012, 3'b000, 3'd0, 3'd4, 2'b01);
      req("R4 write blocked", mk(16'h0011, 3'd0), 1'b1);
      req("R4 read allowed", mk(16'h0011, 3'd0), 1'b0);
      set_win(0, 16'h0010, 16'h0012, 3'b000, 3'd0, 3'd4, 2'b10);
      req("R4 read blocked", mk(16'h0011, 3'd0), 1'b0);
      req("R4 write allowed", mk(16'h0011, 3'd0), 1'b1);

      // R5 interleave codes
      set_win(1, 16'h0020, 16'h0020, 3'b001, 3'd1, 3'd2, 2'b11);
      req("R5 two-way match", mk(16'h0020, 3'b001), 1'b0);
      req("R5 two-way miss", mk(16'h0020, 3'b110), 1'b0);
      set_win(1, 16'h0020, 16'h0020, 3'b011, 3'b101, 3'd2, 2'b11);
      req("R5 four-way A13 ignored", mk(16'h0020, 3'b111), 1'b0);
      req("R5 four-way exact", mk(16'h0020, 3'b101), 1'b0);
      req("R5 four-way miss", mk(16'h0020, 3'b100), 1'b0);
      set_win(1, 16'h0020, 16'h0020, 3'b111, 3'b110, 3'd2, 2'b11);
      req("R5 eight-way match", mk(16'h0020, 3'b110), 1'b0);
      req("R5 eight-way miss", mk(16'h0020, 3'b111), 1'b0);

      // R6 reserved codes
      set_win(1, 16'h0020, 16'h0020, 3'b010, 3'd0, 3'd2, 2'b11);
      req("R6 reserved code", mk(16'h0020, 3'b000), 1'b0);
      set_win(1, 16'h0020, 16'h0020, 3'b110, 3'd0, 3'd2, 2'b11);
      req("R6 reserved code 110", mk(16'h0020, 3'b000), 1'b0);
      clear_all();

      // R7 priority, R9 node source
      set_win(5, 16'h0030, 16'h0040, 3'b000, 3'd0, 3'd6, 2'b11);
      set_win(2, 16'h0035, 16'h0038, 3'b000, 3'd0, 3'd3, 2'b11);
      req("R7 lowest index wins", mk(16'h0036, 3'd0), 1'b0);
      req("R9 node from upper word", mk(16'h0031, 3'd0), 1'b1);

      // R10 idle
      @(negedge clk);
      req_valid = 1'b0; req_addr = mk(16'h0036, 3'd0);
      @(negedge clk);
      check("R10 idle response", {30'd0, rsp_valid, rsp_hit}, 32'd0);
      clear_all();

      // random rounds
      for (int r = 0; r < 12; r++) begin
         for (int i = 0; i < 8; i++) begin
            logic [15:0] lo;
            logic [2:0] cd;
            lo = 16'($urandom_range(0, 200));
            case ($urandom_range(0, 4))
               0: cd = 3'b000; 1: cd = 3'b001; 2: cd = 3'b011; 3: cd = 3'b111;
               default: cd = 3'($urandom_range(0, 7));
            endcase
            set_win(i, lo, lo + 16'($urandom_range(0, 30)), cd,
                    3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                    2'($urandom_range(0, 3)));
         end
         for (int k = 0; k < 60; k++) begin
            req("R3 R5 R7 R9 random", {16'($urandom_range(0, 240)), 24'($urandom)},
                1'($urandom_range(0, 1)));
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule